// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It walks a two-level radix tree of page-table entries held in memory. A request carries the virtual address, an access type (read or write) and a privilege level (supervisor or user). The walker reads a first-level entry, then a second-level entry, and checks the valid and permission bits. It then reports either the physical address or a fault code. Pages are 4 KiB, so the low 12 address bits pass through unchanged. Every table node is 4 KiB and holds 1024 four-byte entries.

Software points the walker at the first-level node of the current address space through a root-pointer write port. The walker talks to memory through a single-word request/response port and keeps at most one read in flight. When a permitted access finds the accessed flag clear, the walker writes the second-level entry back before it reports completion. It does the same when a write finds the dirty flag clear.

Entry layout, shared by both levels:

| Bits | Meaning |
|------|---------|
| 31 | valid |
| 30:11 | 20-bit frame number |
| 10 / 9 | supervisor read / supervisor write |
| 8 / 7 | user read / user write |
| 6 / 5 | accessed / dirty |
| 4:0 | reserved, ignored |

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req_valid` and `done_valid` are 0.
- R2: The first-level read address is `{root[31:12], vaddr[31:22], 2'b00}`. The low 12 bits written to the root pointer are ignored.
- R3: The second-level read address is `{L1_entry[30:11], vaddr[21:12], 2'b00}`.
- R4: A successful walk reports `done_fault` = 2'b00 and `done_paddr` = `{L2_entry[30:11], vaddr[11:0]}`.
- R5: A first-level entry with bit 31 clear ends the walk with `done_fault` = 2'b01. That walk issues exactly one memory read and reports `done_paddr` = 0.
- R6: A second-level entry with bit 31 clear ends the walk with `done_fault` = 2'b10 and `done_paddr` = 0.
- R7: The walker selects one permission bit from the second-level entry. A supervisor read uses bit 10, a supervisor write bit 9, a user read bit 8 and a user write bit 7. If that bit is clear, the walk ends with `done_fault` = 2'b11.
- R8: A permitted access issues one write to the second-level entry address before `done_valid` when bit 6 is clear, or when the access is a write and bit 5 is clear. The write data is the entry with bit 6 set, and with bit 5 also set for a write. In every other case no write is issued.
- R9: A walk that ends in any fault issues no memory write.
- R10: Reserved bits 4:0 of an entry do not affect translation, and the write-back keeps them unchanged.
- R11: A root-pointer write made while a walk is in progress takes effect only once the walker is idle again, and the last such write wins. The current walk still uses the old root.
- R12: `req_ready` is 1 only while idle. A memory request stays asserted, with a stable address, until `mem_req_ready` accepts it, and at most one read is outstanding.
- R13: Each accepted request produces exactly one `done_valid` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_wr_en | input | 1 | Root-pointer write strobe |
| root_wr_data | input | 32 | Physical address of the first-level node |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = entry write-back, 0 = entry read |
| mem_req_addr | output | 32 | Word address of the entry |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 32 | Entry read from memory |
| done_valid | output | 1 | One-cycle completion pulse |
| done_paddr | output | 32 | Physical address (0 on fault) |
| done_fault | output | 2 | 00 none, 01 first-level invalid, 10 second-level invalid, 11 permission |

## Verification
Supervisor and user reads and writes run against entries whose accessed and dirty flags are clear, partly set or fully set. These separate a walk that needs no write-back, one that sets only the accessed flag, and one that also sets the dirty flag. A sweep puts each single permission bit against all four access kinds, which tells a correct bit selection from any swapped index. Entries that are invalid at each level, and entries with junk in the reserved bits, show where the walk stops and what it ignores. A memory that withholds ready on most cycles, combined with root writes landing mid-walk, separates deferred root updates from immediate ones and checks that requests stay steady under back-pressure.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned IDX_W  = 10;
  localparam int unsigned PFN_W  = ADDR_W - OFF_W;
  localparam int unsigned L2_LO  = OFF_W;
  localparam int unsigned L1_LO  = OFF_W + IDX_W;
  localparam int unsigned ENT_SH = 2;

  // entry field positions (decoded by software and by this walker)
  localparam int unsigned E_V      = 31;
  localparam int unsigned E_PFN_LO = 11;
  localparam int unsigned E_SR     = 10;
  localparam int unsigned E_SW     = 9;
  localparam int unsigned E_UR     = 8;
  localparam int unsigned E_UW     = 7;
  localparam int unsigned E_A      = 6;
  localparam int unsigned E_D      = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_L1, ST_WAIT_L1, ST_READ_L2, ST_WAIT_L2, ST_UPDATE, ST_DONE
  } walk_state_t;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_DIR  = 2'b01,
    FLT_LEAF = 2'b10,
    FLT_PERM = 2'b11
  } walk_fault_t;
endpackage

// File: rtl/ptw_root_reg.sv
module ptw_root_reg
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PFN_W-1:0] wr_frame,
  input  logic             walker_idle,
  output logic [PFN_W-1:0] root_frame
);
  logic [PFN_W-1:0] root_q, root_d;
  logic [PFN_W-1:0] pend_q, pend_d;
  logic             pend_v_q, pend_v_d;
  logic             root_en, pend_en;

  always_comb begin
    root_d   = root_q;
    pend_d   = pend_q;
    pend_v_d = pend_v_q;
    root_en  = 1'b0;
    pend_en  = 1'b0;
    if (walker_idle) begin
      // newest write wins over a parked one
      if (wr_en) begin
        root_d  = wr_frame;
        root_en = 1'b1;
      end else if (pend_v_q) begin
        root_d  = pend_q;
        root_en = 1'b1;
      end
      pend_v_d = 1'b0;
      pend_en  = pend_v_q;
    end else if (wr_en) begin
      pend_d   = wr_frame;
      pend_v_d = 1'b1;
      pend_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q   <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else begin
      if (root_en) root_q <= root_d;
      if (pend_en) begin
        pend_q   <= pend_d;
        pend_v_q <= pend_v_d;
      end
    end
  end

  assign root_frame = root_q;
endmodule

// File: rtl/ptw_perm_eval.sv
module ptw_perm_eval
  import ptw_pkg::*;
(
  input  logic [ADDR_W-1:0] entry,
  input  logic              is_write,
  input  logic              is_user,
  output logic              allow,
  output logic              need_upd,
  output logic [ADDR_W-1:0] upd_entry
);
  always_comb begin
    unique case ({is_user, is_write})
      2'b00:   allow = entry[E_SR];
      2'b01:   allow = entry[E_SW];
      2'b10:   allow = entry[E_UR];
      default: allow = entry[E_UW];
    endcase
    need_upd = !entry[E_A] || (is_write && !entry[E_D]);
    upd_entry = entry;
    upd_entry[E_A] = 1'b1;
    if (is_write) upd_entry[E_D] = 1'b1;
  end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  output logic              req_ready,
  input  logic [PFN_W-1:0]  root_frame,
  input  logic              perm_allow,
  input  logic              perm_need_upd,
  input  logic [ADDR_W-1:0] perm_upd_entry,
  output logic              acc_write,
  output logic              acc_user,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [ADDR_W-1:0] mem_req_wdata,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_v,
  input  logic [PFN_W-1:0]  mem_rsp_pfn,
  output logic              done_valid,
  output logic [ADDR_W-1:0] done_paddr,
  output logic [1:0]        done_fault,
  output logic              walker_idle
);
  walk_state_t       st_q, st_d;
  logic [ADDR_W-1:0] va_q;
  logic              wr_q, usr_q;
  logic [PFN_W-1:0]  node_q, node_d;
  logic [ADDR_W-1:0] ent_q, ent_d;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [1:0]        flt_q, flt_d;
  logic              cap_en, node_en, ent_en, res_en;

  always_comb begin
    st_d    = st_q;
    node_d  = node_q;
    ent_d   = ent_q;
    pa_d    = pa_q;
    flt_d   = flt_q;
    cap_en  = 1'b0;
    node_en = 1'b0;
    ent_en  = 1'b0;
    res_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        cap_en = 1'b1;
        res_en = 1'b1;
        pa_d   = '0;
        flt_d  = FLT_NONE;
        st_d   = ST_READ_L1;
      end
      ST_READ_L1: if (mem_req_ready) st_d = ST_WAIT_L1;
      ST_WAIT_L1: if (mem_rsp_valid) begin
        if (!mem_rsp_v) begin
          res_en = 1'b1;
          flt_d  = FLT_DIR;
          st_d   = ST_DONE;
        end else begin
          node_en = 1'b1;
          node_d  = mem_rsp_pfn;
          st_d    = ST_READ_L2;
        end
      end
      ST_READ_L2: if (mem_req_ready) st_d = ST_WAIT_L2;
      ST_WAIT_L2: if (mem_rsp_valid) begin
        res_en = 1'b1;
        if (!mem_rsp_v) begin
          flt_d = FLT_LEAF;
          st_d  = ST_DONE;
        end else if (!perm_allow) begin
          flt_d = FLT_PERM;
          st_d  = ST_DONE;
        end else begin
          pa_d   = {mem_rsp_pfn, va_q[OFF_W-1:0]};
          ent_en = 1'b1;
          ent_d  = perm_upd_entry;
          st_d   = perm_need_upd ? ST_UPDATE : ST_DONE;
        end
      end
      ST_UPDATE: if (mem_req_ready) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      va_q   <= '0;
      wr_q   <= 1'b0;
      usr_q  <= 1'b0;
      node_q <= '0;
      ent_q  <= '0;
      pa_q   <= '0;
      flt_q  <= FLT_NONE;
    end else begin
      st_q <= st_d;
      if (cap_en) begin
        va_q  <= req_vaddr;
        wr_q  <= req_write;
        usr_q <= req_user;
      end
      if (node_en) node_q <= node_d;
      if (ent_en)  ent_q  <= ent_d;
      if (res_en) begin
        pa_q  <= pa_d;
        flt_q <= flt_d;
      end
    end
  end

  always_comb begin
    mem_req_valid = (st_q == ST_READ_L1) || (st_q == ST_READ_L2) || (st_q == ST_UPDATE);
    mem_req_write = (st_q == ST_UPDATE);
    if (st_q == ST_READ_L1)
      mem_req_addr = {root_frame, va_q[ADDR_W-1:L1_LO], {ENT_SH{1'b0}}};
    else
      mem_req_addr = {node_q, va_q[L1_LO-1:L2_LO], {ENT_SH{1'b0}}};
    mem_req_wdata = (st_q == ST_UPDATE) ? ent_q : '0;
  end

  assign req_ready   = (st_q == ST_IDLE);
  assign walker_idle = (st_q == ST_IDLE);
  assign done_valid  = (st_q == ST_DONE);
  assign done_paddr  = pa_q;
  assign done_fault  = flt_q;
  assign acc_write   = wr_q;
  assign acc_user    = usr_q;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              root_wr_en,
  input  logic [ADDR_W-1:0] root_wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [ADDR_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_rdata,
  output logic              done_valid,
  output logic [ADDR_W-1:0] done_paddr,
  output logic [1:0]        done_fault
);
  logic [PFN_W-1:0]  root_frame;
  logic              walker_idle;
  logic              acc_write, acc_user;
  logic              perm_allow, perm_need_upd;
  logic [ADDR_W-1:0] perm_upd_entry;
  logic              root_lo_unused;

  assign root_lo_unused = ^root_wr_data[OFF_W-1:0];

  ptw_root_reg u_root (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (root_wr_en),
    .wr_frame    (root_wr_data[ADDR_W-1:OFF_W]),
    .walker_idle (walker_idle),
    .root_frame  (root_frame)
  );

  ptw_perm_eval u_perm (
    .entry     (mem_rsp_rdata),
    .is_write  (acc_write),
    .is_user   (acc_user),
    .allow     (perm_allow),
    .need_upd  (perm_need_upd),
    .upd_entry (perm_upd_entry)
  );

  ptw_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_vaddr      (req_vaddr),
    .req_write      (req_write),
    .req_user       (req_user),
    .req_ready      (req_ready),
    .root_frame     (root_frame),
    .perm_allow     (perm_allow),
    .perm_need_upd  (perm_need_upd),
    .perm_upd_entry (perm_upd_entry),
    .acc_write      (acc_write),
    .acc_user       (acc_user),
    .mem_req_valid  (mem_req_valid),
    .mem_req_write  (mem_req_write),
    .mem_req_addr   (mem_req_addr),
    .mem_req_wdata  (mem_req_wdata),
    .mem_req_ready  (mem_req_ready),
    .mem_rsp_valid  (mem_rsp_valid),
    .mem_rsp_v      (mem_rsp_rdata[E_V]),
    .mem_rsp_pfn    (mem_rsp_rdata[E_V-1:E_PFN_LO]),
    .done_valid     (done_valid),
    .done_paddr     (done_paddr),
    .done_fault     (done_fault),
    .walker_idle    (walker_idle)
  );
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [31:0] mem_req_addr,
  input logic        wb_valid_bit,
  input logic        wb_acc_bit,
  input logic        done_valid,
  input logic [31:0] done_paddr,
  input logic [1:0]  done_fault
);
  // R12
  idle_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  // R13
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !req_ready);

  // R8
  wb_then_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && mem_req_write) |=>
      (done_valid && done_fault == 2'b00));

  // R8
  wb_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> (wb_valid_bit && wb_acc_bit));

  // R5
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault != 2'b00) |-> (done_paddr == 32'h0));
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .wb_valid_bit  (mem_req_wdata[31]),
  .wb_acc_bit    (mem_req_wdata[6]),
  .done_valid    (done_valid),
  .done_paddr    (done_paddr),
  .done_fault    (done_fault)
);

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
  logic        clk, rst_n;
  logic        root_wr_en;
  logic [31:0] root_wr_data;
  logic        req_valid, req_ready, req_write, req_user;
  logic [31:0] req_vaddr;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic        done_valid;
  logic [31:0] done_paddr;
  logic [1:0]  done_fault;

  ptw_walker u0 (
    .clk(clk), .rst_n(rst_n),
    .root_wr_en(root_wr_en), .root_wr_data(root_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .done_valid(done_valid), .done_paddr(done_paddr), .done_fault(done_fault)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // memory model state
  logic [31:0] mem [logic [31:0]];
  bit          stall_en = 1'b0;
  int          cyc = 0;
  int          reads_cnt, wr_cnt;
  logic [31:0] rd_addr [4];
  logic [31:0] wr_addr_l, wr_data_l;

  // walk results
  logic [31:0] w_paddr;
  logic [1:0]  w_fault;
  bit          w_done, w_busy_rdy, w_pulse_ok;

  localparam logic [31:0] VA_A  = 32'h0040_3ABC;
  localparam logic [31:0] L1A   = 32'h0010_0004;
  localparam logic [31:0] L2A   = 32'h0020_000C;

  function automatic logic [31:0] mk(bit v, logic [19:0] pfn, logic [3:0] perm,
                                     bit a, bit d, logic [4:0] rsv);
    return {v, pfn, perm, a, d, rsv};
  endfunction

  function automatic logic [31:0] rd_mem(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // memory responder: one-cycle read latency, writes land on acceptance
  initial begin
    bit          hs_prev;
    bit          hs_wr;
    logic [31:0] hs_addr, hs_data;
    hs_prev = 1'b0; hs_wr = 1'b0; hs_addr = '0; hs_data = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_rdata = '0;
    reads_cnt = 0; wr_cnt = 0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (hs_prev) begin
        if (hs_wr) begin
          mem[hs_addr] = hs_data;
          wr_addr_l = hs_addr;
          wr_data_l = hs_data;
          wr_cnt++;
        end else begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = rd_mem(hs_addr);
          if (reads_cnt < 4) rd_addr[reads_cnt] = hs_addr;
          reads_cnt++;
        end
      end
      mem_req_ready = !stall_en || (cyc % 3 == 0);
      #1;
      hs_prev = mem_req_valid && mem_req_ready;
      hs_wr   = mem_req_write;
      hs_addr = mem_req_addr;
      hs_data = mem_req_wdata;
    end
  end

  // caller is at a negedge with the walker idle
  task automatic do_walk(logic [31:0] va, bit wr, bit usr);
    int n;
    reads_cnt = 0; wr_cnt = 0;
    rd_addr[0] = '0; rd_addr[1] = '0; wr_addr_l = '0; wr_data_l = '0;
    w_busy_rdy = 1'b0; w_done = 1'b0; w_pulse_ok = 1'b1;
    w_paddr = 32'hDEAD_BEEF; w_fault = 2'bxx;
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done_valid && n < 100) begin
      if (req_ready) w_busy_rdy = 1'b1;
      @(negedge clk);
      n++;
    end
    if (done_valid) begin
      w_done = 1'b1; w_paddr = done_paddr; w_fault = done_fault;
    end
    @(negedge clk);
    if (done_valid) w_pulse_ok = 1'b0;
  endtask

  task automatic write_root(logic [31:0] v);
    root_wr_en = 1'b1; root_wr_data = v;
    @(negedge clk);
    root_wr_en = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "req_ready after reset", {31'b0, req_ready}, 32'd1);
    chk("R1", "mem_req_valid after reset", {31'b0, mem_req_valid}, 32'd0);
    chk("R1", "done_valid after reset", {31'b0, done_valid}, 32'd0);
  endtask

  task automatic t_basic;
    logic [31:0] e;
    e = mk(1, 20'h12345, 4'b1000, 0, 0, 5'h0);
    mem[L2A] = e;
    @(negedge clk);
    do_walk(VA_A, 0, 0);
    chk("R13", "done seen", {31'b0, w_done}, 32'd1);
    chk("R2", "first-level address", rd_addr[0], L1A);
    chk("R3", "second-level address", rd_addr[1], L2A);
    chk("R4", "paddr", w_paddr, 32'h1234_5ABC);
    chk("R4", "fault", {30'b0, w_fault}, 32'd0);
    chk("R8", "write count read", wr_cnt, 32'd1);
    chk("R8", "write address", wr_addr_l, L2A);
    chk("R8", "write data accessed", wr_data_l, e | 32'h40);
    chk("R13", "single-cycle pulse", {31'b0, w_pulse_ok}, 32'd1);
    chk("R12", "req_ready low while busy", {31'b0, w_busy_rdy}, 32'd0);
  endtask

  task automatic t_dirty;
    logic [31:0] e;
    e = mk(1, 20'h0BEEF, 4'b0001, 1, 0, 5'h0);
    mem[L2A] = e;
    @(negedge clk);
    do_walk(VA_A, 1, 1);
    chk("R4", "paddr user write", w_paddr, 32'h0BEE_FABC);
    chk("R8", "write count dirty", wr_cnt, 32'd1);
    chk("R8", "write data dirty", wr_data_l, e | 32'h60);
  endtask

  task automatic t_clean;
    mem[L2A] = mk(1, 20'h00777, 4'b1111, 1, 1, 5'h0);
    @(negedge clk);
    do_walk(VA_A, 1, 0);
    chk("R4", "paddr no-update", w_paddr, 32'h0077_7ABC);
    chk("R8", "no write when A and D set", wr_cnt, 32'd0);
    mem[L2A] = mk(1, 20'h00777, 4'b1111, 1, 0, 5'h0);
    @(negedge clk);
    do_walk(VA_A, 0, 1);
    chk("R8", "no write on read with A set, D clear", wr_cnt, 32'd0);
  endtask

  task automatic t_l1_inv;
    mem[32'h0010_0008] = mk(0, 20'hABCDE, 4'hF, 1, 1, 5'h0);
    @(negedge clk);
    do_walk(32'h0080_0123, 0, 0);
    chk("R5", "fault first-level", {30'b0, w_fault}, 32'd1);
    chk("R5", "single read", reads_cnt, 32'd1);
    chk("R5", "paddr zero", w_paddr, 32'h0);
    chk("R9", "no write on first-level fault", wr_cnt, 32'd0);
  endtask

  task automatic t_l2_inv;
    mem[L2A] = mk(0, 20'h12345, 4'hF, 0, 0, 5'h0);
    @(negedge clk);
    do_walk(VA_A, 0, 0);
    chk("R6", "fault second-level", {30'b0, w_fault}, 32'd2);
    chk("R6", "paddr zero", w_paddr, 32'h0);
    chk("R9", "no write on second-level fault", wr_cnt, 32'd0);
  endtask

  task automatic t_perm;
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 4; c++) begin
        logic [3:0] perm;
        bit         ok;
        perm = 4'b1000 >> p;
        ok   = perm[3-c];
        mem[L2A] = mk(1, 20'h0CAFE, perm, 0, 0, 5'h0);
        @(negedge clk);
        do_walk(VA_A, c[0], c[1]);
        chk("R7", $sformatf("fault perm=%b user=%0d write=%0d", perm, c[1], c[0]),
            {30'b0, w_fault}, ok ? 32'd0 : 32'd3);
        chk("R9", "write count after permission check", wr_cnt, ok ? 32'd1 : 32'd0);
      end
    end
  endtask

  task automatic t_rsv;
    logic [31:0] e;
    e = mk(1, 20'h5A5A5, 4'b1000, 0, 0, 5'h1F);
    mem[L2A] = e;
    @(negedge clk);
    do_walk(VA_A, 0, 0);
    chk("R10", "paddr with reserved bits set", w_paddr, 32'h5A5A_5ABC);
    chk("R10", "reserved bits kept in write-back", wr_data_l, e | 32'h40);
  endtask

  task automatic t_root_defer;
    logic [31:0] l1e;
    l1e = mk(1, 20'h00200, 4'h0, 0, 0, 5'h0);
    mem[32'h0030_0004] = l1e;
    mem[32'h0040_0004] = l1e;
    mem[L2A] = mk(1, 20'h31415, 4'b1000, 1, 1, 5'h0);
    stall_en = 1'b1;
    @(negedge clk);
    fork
      do_walk(VA_A, 0, 0);
      begin
        repeat (2) @(negedge clk);
        write_root(32'h0030_0000);
        write_root(32'h0040_0000);
      end
    join
    chk("R11", "walk in progress keeps old root", rd_addr[0], L1A);
    chk("R12", "paddr under back-pressure", w_paddr, 32'h3141_5ABC);
    chk("R12", "req_ready low while stalled", {31'b0, w_busy_rdy}, 32'd0);
    stall_en = 1'b0;
    @(negedge clk);
    do_walk(VA_A, 0, 0);
    chk("R11", "last deferred root applied", rd_addr[0], 32'h0040_0004);
    chk("R4", "paddr after root switch", w_paddr, 32'h3141_5ABC);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R13 watchdog: actual=no completion expected=finished run");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; root_wr_en = 1'b0; root_wr_data = '0;
    req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_user = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    mem[L1A] = mk(1, 20'h00200, 4'h0, 0, 0, 5'h0);
    @(negedge clk);
    write_root(32'h0010_0ABC);  // low bits ignored (R2)
    t_basic();
    t_dirty();
    t_clean();
    t_l1_inv();
    t_l2_inv();
    t_perm();
    t_rsv();
    t_root_defer();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule